// File: doc/BRIEF.md
# Wakeup Scheduler with Register Busy Table

This block sits in the back end of an out-of-order core, between renaming and the functional units. It holds one busy bit for each physical register, plus a small pool of instruction slots. A renamed instruction is written into a free slot together with its two source tags and its destination tag. The busy table supplies the readiness of each source. Writing the instruction also marks its destination as busy.

When a functional unit reports a result for a tag, that tag's busy bit clears. Every waiting slot that names the tag as a source is woken. Each cycle, the lowest-numbered slot whose sources are both ready is offered to the functional unit. The slot is released when the unit accepts it.

Within one cycle the three actions take effect in a fixed order: result reporting, then instruction entry, then selection. Because of this order, a result can be consumed in the cycle it is produced. An instruction can issue in the cycle it enters, and in the cycle its last operand arrives, with no extra cycle of latency.

Each slot runs a small state machine with three states:
- `SLOT_EMPTY`: the slot holds nothing.
- `SLOT_WAIT`: the slot is occupied and at least one source is not ready.
- `SLOT_ARMED`: the slot is occupied and both sources are ready.

The transitions are:
- fill: `SLOT_EMPTY` to `SLOT_WAIT`, or to `SLOT_ARMED` when both sources are ready at entry.
- pass-through: `SLOT_EMPTY` to `SLOT_EMPTY`, when the entry is written and accepted in the same cycle.
- wake: `SLOT_WAIT` to `SLOT_ARMED`.
- wake-and-go: `SLOT_WAIT` to `SLOT_EMPTY`.
- issue: `SLOT_ARMED` to `SLOT_EMPTY`.

Top module: `wakeup_sched`

## Requirements
- R1: After reset every slot is empty and every register is not busy: `iss_valid` is 0 and `ins_ready` is 1.
- R2: An accepted entry sets the busy bit of `ins_dst`. A later entry that reads that tag waits and is not offered for issue.
- R3: A result report (`fin_valid`, `fin_tag`) clears that tag's busy bit, so entries written in later cycles see the tag as ready.
- R4: A result reported in the same cycle as an entry write is seen as ready by that entry, which can be offered in that same cycle.
- R5: An entry whose sources are ready can be offered (`iss_valid`=1 with its `iss_id` and `iss_dst`) in the cycle it is written, when no lower-numbered slot is ready.
- R6: A waiting entry is offered in the cycle its last busy source is reported.
- R7: New entries take the lowest-numbered free slot, and among ready slots the lowest-numbered one is offered.
- R8: With every slot occupied, `ins_ready` is 0. An entry presented then is ignored: it is never issued and its destination busy bit is not set.
- R9: While `iss_ready` is 0, an offered entry stays in its slot and keeps being offered with the same `iss_id`.
- R10: No entry is offered before both its sources are ready, and every accepted entry is issued once its sources have been reported.
- R11: When an entry write allocates the same tag that is reported finished in that cycle, the tag ends the cycle busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Entry write request |
| ins_src0 | input | TAGW | First source physical tag |
| ins_src1 | input | TAGW | Second source physical tag |
| ins_dst | input | TAGW | Destination physical tag, marked busy on accept |
| ins_id | input | IDW | Instruction identifier carried to issue |
| ins_ready | output | 1 | A slot is free; the write is accepted when both valid and ready |
| fin_valid | input | 1 | Result report valid |
| fin_tag | input | TAGW | Tag whose result is now available |
| iss_ready | input | 1 | Functional unit accepts the offered entry |
| iss_valid | output | 1 | An entry is offered for issue |
| iss_id | output | IDW | Identifier of the offered entry |
| iss_dst | output | TAGW | Destination tag of the offered entry |

## Verification
Directed cycles cover the same-cycle cases one at a time:
- an entry written with all sources ready, which tells entry-then-select from a one-cycle delay;
- a source reported in the entry's own cycle, which tells report-then-entry from stale readiness;
- a waiting entry whose operand is reported, which tells report-then-select from a one-cycle wakeup;
- a destination allocated and reported in the same cycle, which shows which of the two updates wins.

A filled pool with a held functional unit shows blocking and in-order slot priority. A follow-up entry that reads the rejected entry's destination shows that the rejected write left no trace. A long mixed stream of random writes, reports and stalls, followed by a drain, compares every cycle with an arithmetic model and confirms that every accepted entry leaves exactly once.

// File: rtl/ws_pkg.sv
package ws_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_ARMED = 2'd2
    } slot_state_e;
endpackage

// File: rtl/ws_picker.sv
// Lowest-index one-hot selector, used for slot allocation and for issue choice.
module ws_picker #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any_o
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign any_o = |req;
endmodule

// File: rtl/ws_busy_table.sv
// One busy bit per physical register; the report bypass is applied on the read side.
module ws_busy_table #(
    parameter int PREGS = 16,
    parameter int TAGW  = $clog2(PREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fin_valid,
    input  logic [TAGW-1:0] fin_tag,
    input  logic            set_valid,
    input  logic [TAGW-1:0] set_tag,
    input  logic [TAGW-1:0] q0,
    input  logic [TAGW-1:0] q1,
    output logic            r0,
    output logic            r1
);
    logic [PREGS-1:0] busy_q;
    logic [PREGS-1:0] busy_d;

    always_comb begin
        busy_d = busy_q;
        if (fin_valid) busy_d[fin_tag] = 1'b0;
        if (set_valid) busy_d[set_tag] = 1'b1;   // allocation wins over same-tag report
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    // Report is ordered before entry write: a same-cycle report reads as ready.
    assign r0 = !busy_q[q0] || (fin_valid && fin_tag == q0);
    assign r1 = !busy_q[q1] || (fin_valid && fin_tag == q1);

    a_r3_finish_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_valid && !(set_valid && set_tag == fin_tag)) |=> !busy_q[$past(fin_tag)]);

    a_r11_alloc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> busy_q[$past(set_tag)]);
endmodule

// File: rtl/ws_slot.sv
// One instruction slot with its own three-state machine.
module ws_slot
    import ws_pkg::*;
#(
    parameter int TAGW = 4,
    parameter int IDW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [TAGW-1:0] wr_src0,
    input  logic [TAGW-1:0] wr_src1,
    input  logic            wr_rdy0,
    input  logic            wr_rdy1,
    input  logic [IDW-1:0]  wr_id,
    input  logic [TAGW-1:0] wr_dst,
    input  logic            fin_valid,
    input  logic [TAGW-1:0] fin_tag,
    input  logic            grant,
    output logic            occ,
    output logic            req,
    output logic [IDW-1:0]  id_o,
    output logic [TAGW-1:0] dst_o
);
    slot_state_e     state_q, state_d;
    logic [TAGW-1:0] src0_q, src1_q, dst_q;
    logic [IDW-1:0]  id_q;
    logic            rdy0_q, rdy1_q;
    logic            e_live, e_r0, e_r1;

    // Effective view this cycle: the incoming entry, or the stored one plus wakeup.
    always_comb begin
        if (wr_en) begin
            e_live = 1'b1;
            e_r0   = wr_rdy0;
            e_r1   = wr_rdy1;
            id_o   = wr_id;
            dst_o  = wr_dst;
        end else begin
            e_live = (state_q != SLOT_EMPTY);
            e_r0   = rdy0_q || (fin_valid && fin_tag == src0_q);
            e_r1   = rdy1_q || (fin_valid && fin_tag == src1_q);
            id_o   = id_q;
            dst_o  = dst_q;
        end
        occ = (state_q != SLOT_EMPTY);
        req = e_live && e_r0 && e_r1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (wr_en) begin
                    if (grant)            state_d = SLOT_EMPTY;  // pass-through
                    else if (e_r0 && e_r1) state_d = SLOT_ARMED; // fill, ready
                    else                  state_d = SLOT_WAIT;   // fill, waiting
                end
            end
            SLOT_WAIT: begin
                if (grant)             state_d = SLOT_EMPTY;     // wake-and-go
                else if (e_r0 && e_r1) state_d = SLOT_ARMED;     // wake
            end
            SLOT_ARMED: begin
                if (grant) state_d = SLOT_EMPTY;                 // issue
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            src0_q  <= '0;
            src1_q  <= '0;
            dst_q   <= '0;
            id_q    <= '0;
            rdy0_q  <= 1'b0;
            rdy1_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rdy0_q  <= e_r0;
            rdy1_q  <= e_r1;
            if (wr_en) begin
                src0_q <= wr_src0;
                src1_q <= wr_src1;
                dst_q  <= wr_dst;
                id_q   <= wr_id;
            end
        end
    end

    a_r9_armed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_ARMED && !grant) |=> (state_q == SLOT_ARMED && $stable(id_q)));

    a_r10_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req);

    a_r10_wait_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT) |-> !(rdy0_q && rdy1_q));
endmodule

// File: rtl/wakeup_sched.sv
module wakeup_sched #(
    parameter int PREGS = 16,
    parameter int SLOTS = 4,
    parameter int IDW   = 4,
    localparam int TAGW = $clog2(PREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_valid,
    input  logic [TAGW-1:0] ins_src0,
    input  logic [TAGW-1:0] ins_src1,
    input  logic [TAGW-1:0] ins_dst,
    input  logic [IDW-1:0]  ins_id,
    output logic            ins_ready,
    input  logic            fin_valid,
    input  logic [TAGW-1:0] fin_tag,
    input  logic            iss_ready,
    output logic            iss_valid,
    output logic [IDW-1:0]  iss_id,
    output logic [TAGW-1:0] iss_dst
);
    logic [SLOTS-1:0] occ, req, free_oh, pick_oh, wr_en, grant;
    logic [SLOTS-1:0] free_vec;
    logic [IDW-1:0]   id_v  [SLOTS];
    logic [TAGW-1:0]  dst_v [SLOTS];
    logic             any_free, ins_fire, rdy0, rdy1;

    assign free_vec = ~occ;

    ws_picker #(.N(SLOTS)) u_alloc (
        .req(free_vec), .gnt(free_oh), .any_o(any_free)
    );

    assign ins_ready = any_free;
    assign ins_fire  = ins_valid && any_free;
    assign wr_en     = free_oh & {SLOTS{ins_fire}};

    ws_busy_table #(.PREGS(PREGS), .TAGW(TAGW)) u_busy (
        .clk(clk), .rst_n(rst_n),
        .fin_valid(fin_valid), .fin_tag(fin_tag),
        .set_valid(ins_fire), .set_tag(ins_dst),
        .q0(ins_src0), .q1(ins_src1),
        .r0(rdy0), .r1(rdy1)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        ws_slot #(.TAGW(TAGW), .IDW(IDW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en[g]),
            .wr_src0(ins_src0), .wr_src1(ins_src1),
            .wr_rdy0(rdy0), .wr_rdy1(rdy1),
            .wr_id(ins_id), .wr_dst(ins_dst),
            .fin_valid(fin_valid), .fin_tag(fin_tag),
            .grant(grant[g]),
            .occ(occ[g]), .req(req[g]),
            .id_o(id_v[g]), .dst_o(dst_v[g])
        );
    end

    ws_picker #(.N(SLOTS)) u_issue (
        .req(req), .gnt(pick_oh), .any_o(iss_valid)
    );

    assign grant = pick_oh & {SLOTS{iss_ready}};

    always_comb begin
        iss_id  = '0;
        iss_dst = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (pick_oh[i]) begin
                iss_id  = iss_id  | id_v[i];
                iss_dst = iss_dst | dst_v[i];
            end
        end
    end

    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_ready |-> (&occ));

    a_r7_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en) && ((wr_en & occ) == '0));
endmodule

// File: tb/test_wakeup_sched.sv
module test_wakeup_sched;
    localparam int PREGS = 16;
    localparam int SLOTS = 4;
    localparam int IDW   = 4;
    localparam int TAGW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 1'b0, fin_valid = 1'b0, iss_ready = 1'b0;
    logic [TAGW-1:0] ins_src0 = '0, ins_src1 = '0, ins_dst = '0, fin_tag = '0;
    logic [IDW-1:0]  ins_id = '0;
    logic ins_ready, iss_valid;
    logic [IDW-1:0]  iss_id;
    logic [TAGW-1:0] iss_dst;

    int n_tests = 0;
    int n_fail  = 0;
    int n_acc   = 0;
    int n_iss   = 0;

    bit m_busy [PREGS];
    bit m_v  [SLOTS];
    bit m_r0 [SLOTS];
    bit m_r1 [SLOTS];
    int m_s0 [SLOTS];
    int m_s1 [SLOTS];
    int m_id [SLOTS];
    int m_dst[SLOTS];

    always #10 clk = ~clk;

    wakeup_sched #(.PREGS(PREGS), .SLOTS(SLOTS), .IDW(IDW)) i_wakeup_sched (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_src0(ins_src0), .ins_src1(ins_src1),
        .ins_dst(ins_dst), .ins_id(ins_id), .ins_ready(ins_ready),
        .fin_valid(fin_valid), .fin_tag(fin_tag),
        .iss_ready(iss_ready), .iss_valid(iss_valid),
        .iss_id(iss_id), .iss_dst(iss_dst)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit iv, input int s0, input int s1, input int d, input int id,
                         input bit fv, input int ft, input bit ir);
        ins_valid = iv;
        ins_src0  = TAGW'(s0);
        ins_src1  = TAGW'(s1);
        ins_dst   = TAGW'(d);
        ins_id    = IDW'(id);
        fin_valid = fv;
        fin_tag   = TAGW'(ft);
        iss_ready = ir;
    endtask

    // Called just after a falling edge with inputs set. ev < 0 skips the explicit check.
    task automatic cyc(input string tag, input int ev, input int eid, input int eir);
        int fs, pk;
        bit fire;
        bit ev_[SLOTS];
        bit e0[SLOTS];
        bit e1[SLOTS];
        int eid_[SLOTS];
        int edst[SLOTS];
        #2;
        fs = -1;
        for (int i = 0; i < SLOTS; i++) if (!m_v[i] && fs < 0) fs = i;
        fire = ins_valid && (fs >= 0);
        for (int i = 0; i < SLOTS; i++) begin
            ev_[i] = 1'b0; e0[i] = 1'b0; e1[i] = 1'b0; eid_[i] = 0; edst[i] = 0;
            if (m_v[i]) begin
                ev_[i] = 1'b1;
                e0[i]  = m_r0[i] || (fin_valid && int'(fin_tag) == m_s0[i]);
                e1[i]  = m_r1[i] || (fin_valid && int'(fin_tag) == m_s1[i]);
                eid_[i] = m_id[i]; edst[i] = m_dst[i];
            end else if (fire && i == fs) begin
                ev_[i] = 1'b1;
                e0[i]  = !m_busy[ins_src0] || (fin_valid && fin_tag == ins_src0);
                e1[i]  = !m_busy[ins_src1] || (fin_valid && fin_tag == ins_src1);
                eid_[i] = int'(ins_id); edst[i] = int'(ins_dst);
            end
        end
        pk = -1;
        for (int i = 0; i < SLOTS; i++) if (pk < 0 && ev_[i] && e0[i] && e1[i]) pk = i;

        if (ev >= 0) begin
            chk(int'(iss_valid) == ev, {tag, " iss_valid"}, int'(iss_valid), ev);
            if (ev == 1) chk(int'(iss_id) == eid, {tag, " iss_id"}, int'(iss_id), eid);
        end
        if (eir >= 0) chk(int'(ins_ready) == eir, {tag, " ins_ready"}, int'(ins_ready), eir);
        chk(iss_valid == (pk >= 0), {tag, " model iss_valid"}, int'(iss_valid), int'(pk >= 0));
        if (pk >= 0 && iss_valid) begin
            chk(int'(iss_id) == eid_[pk], {tag, " model iss_id"}, int'(iss_id), eid_[pk]);
            chk(int'(iss_dst) == edst[pk], {tag, " model iss_dst"}, int'(iss_dst), edst[pk]);
        end
        chk(ins_ready == (fs >= 0), {tag, " model ins_ready"}, int'(ins_ready), int'(fs >= 0));

        if (fin_valid) m_busy[fin_tag] = 1'b0;
        if (fire) begin m_busy[ins_dst] = 1'b1; n_acc++; end
        for (int i = 0; i < SLOTS; i++) begin
            if (pk == i && iss_ready) begin
                m_v[i] = 1'b0;
                n_iss++;
            end else if (ev_[i]) begin
                m_v[i] = 1'b1; m_r0[i] = e0[i]; m_r1[i] = e1[i];
                if (!(m_v[i] && i != fs) || !fire) begin end
                if (fire && i == fs) begin
                    m_s0[i] = int'(ins_src0); m_s1[i] = int'(ins_src1);
                end
                m_id[i] = eid_[i]; m_dst[i] = edst[i];
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < PREGS; i++) m_busy[i] = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            m_v[i] = 1'b0; m_r0[i] = 1'b0; m_r1[i] = 1'b0;
            m_s0[i] = 0; m_s1[i] = 0; m_id[i] = 0; m_dst[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        drive(0, 0, 0, 0, 0, 0, 0, 1); cyc("R1 reset", 0, 0, 1);
        drive(1, 1, 2, 5, 1, 0, 0, 1); cyc("R5 same-cycle issue", 1, 1, 1);
        drive(1, 5, 0, 6, 2, 0, 0, 1); cyc("R2 busy source waits", 0, 0, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1); cyc("R2 still waiting", 0, 0, 1);
        drive(0, 0, 0, 0, 0, 1, 5, 1); cyc("R6 wake on last source", 1, 2, 1);
        drive(1, 6, 6, 7, 3, 1, 6, 1); cyc("R4 report then entry", 1, 3, 1);
        drive(1, 1, 1, 8, 4, 1, 8, 0); cyc("R11 alloc and report", 1, 4, 1);
        drive(1, 8, 8, 9, 5, 0, 0, 0); cyc("R11 R9 tag stays busy", 1, 4, 1);
        drive(0, 0, 0, 0, 0, 1, 8, 0); cyc("R7 lowest ready first", 1, 4, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1); cyc("R7 slot0 goes", 1, 4, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1); cyc("R7 slot1 goes", 1, 5, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1); cyc("R3 empty again", 0, 0, 1);
        drive(1, 0, 0, 10, 6, 0, 0, 0); cyc("R8 fill 0", 1, 6, 1);
        drive(1, 10, 10, 11, 7, 0, 0, 0); cyc("R8 fill 1", 1, 6, 1);
        drive(1, 10, 10, 12, 8, 0, 0, 0); cyc("R8 fill 2", 1, 6, 1);
        drive(1, 10, 10, 13, 9, 0, 0, 0); cyc("R8 fill 3", 1, 6, 1);
        drive(1, 0, 0, 14, 15, 0, 0, 0); cyc("R8 full blocks", 1, 6, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 1); cyc("R8 R9 held entry goes", 1, 6, 0);
        drive(0, 0, 0, 0, 0, 1, 10, 1); cyc("R6 R7 wake three", 1, 7, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1); cyc("R7 next", 1, 8, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1); cyc("R7 last", 1, 9, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1); cyc("R8 rejected never issues", 0, 0, 1);
        drive(1, 14, 14, 0, 10, 0, 0, 1); cyc("R8 R3 rejected dst not busy", 1, 10, 1);

        for (int n = 0; n < 4000; n++) begin
            drive(($urandom % 3) != 0, $urandom % 8, $urandom % 8, $urandom % PREGS,
                  n % 16, ($urandom % 2) == 1, $urandom % PREGS, ($urandom % 4) != 0);
            cyc("R10 sweep", -1, 0, -1);
        end
        for (int t = 0; t < 2 * PREGS; t++) begin
            drive(0, 0, 0, 0, 0, 1, t % PREGS, 1);
            cyc("R10 drain", -1, 0, -1);
        end
        for (int t = 0; t < SLOTS + 2; t++) begin
            drive(0, 0, 0, 0, 0, 0, 0, 1);
            cyc("R10 drain idle", -1, 0, -1);
        end
        chk(n_acc == n_iss, "R10 every accepted entry issued", n_iss, n_acc);
        chk(iss_valid == 1'b0, "R10 pool empty", int'(iss_valid), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule